// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one timer channel that software drives through four word-wide registers: a start count, the live count, a control word and an interrupt acknowledge. Software writes the start count, then writes the control word with the run bit set. The channel copies the start count into the live counter and then counts down by one on each pulse of the tick enable that the control word selects. Two tick-enable inputs arrive from outside: a fast one (about 508 kHz) and a slow one.

When a tick arrives while the counter is at zero, the count underflows and the interrupt output goes high and stays high. In periodic mode the counter then reloads the start count and keeps running. In free mode it wraps to the all-ones value of its width. To reprogram the channel, software clears the run bit, writes a new start count and sets the run bit again. The count width is a parameter and may be 16 or 32 bits.

Top module: `reload_timer`

## Requirements
- R1: After reset the start count, live count and control readback all read 0, and `irq` is low.
- R2: The start-count register (word offset 0x0) reads back the last value written to it. The live-count register (0x4) is read-only, so writes to it have no effect.
- R3: A control write that sets the run bit (bit 7) while the channel is stopped copies the start count into the live count in that cycle, and no decrement happens in that cycle.
- R4: While the channel runs, the live count drops by one on each cycle in which the selected tick is high. Control bit 3 = 1 selects `fastTick` and 0 selects `slowTick`. The tick that is not selected has no effect.
- R5: While the run bit is 0, the live count holds its value whatever the tick inputs do.
- R6: A selected tick while the live count is 0 sets `irq` on the next cycle. With control bit 6 = 1 (periodic), the live count then reloads the start count.
- R7: With control bit 6 = 0, an underflow wraps the live count to all ones of its width and sets `irq`.
- R8: A write of any data to the acknowledge register (0xC) clears `irq`. If an underflow happens in the same cycle, the underflow wins and `irq` stays high.
- R9: Once `irq` is high it stays high until an acknowledge write or a control write with bit 7 = 0. A control write with bit 7 = 0 clears `irq` and suppresses any tick in that cycle.
- R10: The control register reads back only bits 7, 6 and 3. Every other bit reads 0.
- R11: With `CNT_W` = 16, the start-count and live-count registers keep only the low 16 bits of a write, and their upper 16 read bits are 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Byte offset of the register; bits [3:2] pick the word |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| fastTick | input | 1 | Fast tick enable, one cycle high per tick |
| slowTick | input | 1 | Slow tick enable, one cycle high per tick |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
The read path is combinational, so a register write or a counter step shows on `regRdData` in the cycle that follows the clock edge that captured it. The bench drives a stimulus on a falling edge and reads back after the next falling edge, one rising edge later. `irq` is a register set by the same edge that performs the underflow step, so it is checked at the same point as the reloaded or wrapped count. To cover the race cases, the acknowledge write and the tick are driven in the same cycle. A disabling control write is likewise driven together with a tick, and the ignored tick is confirmed through the live-count readback.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  // word index of each register (byte offset bits [3:2])
  localparam logic [1:0] WIDX_LOAD  = 2'd0;
  localparam logic [1:0] WIDX_VALUE = 2'd1;
  localparam logic [1:0] WIDX_CTRL  = 2'd2;
  localparam logic [1:0] WIDX_ACK   = 2'd3;

  // control word bit positions
  localparam int RUN_BIT  = 7;
  localparam int PER_BIT  = 6;
  localparam int FAST_BIT = 3;

  typedef struct packed {
    logic doLoad;   // copy start count into the live counter
    logic doStep;   // a selected tick while running
    logic clrIrq;   // acknowledge or disable
  } tmr_strobe_t;
endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              fastTick,
  input  logic              slowTick,
  output logic [CNT_W-1:0]  loadVal,
  output logic              ctlEn,
  output logic              ctlPer,
  output logic              ctlFast,
  output tmr_strobe_t       strobe
);
  logic [1:0] wordIdx;
  logic wrLoad, wrCtrl, wrAck, newRun, tickSel, stopNow;

  assign wordIdx = regAddr[3:2];
  assign wrLoad  = regWrEn && (wordIdx == WIDX_LOAD);
  assign wrCtrl  = regWrEn && (wordIdx == WIDX_CTRL);
  assign wrAck   = regWrEn && (wordIdx == WIDX_ACK);
  assign newRun  = regWrData[RUN_BIT];
  assign stopNow = wrCtrl && !newRun;
  assign tickSel = ctlFast ? fastTick : slowTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal <= '0;
      ctlEn   <= 1'b0;
      ctlPer  <= 1'b0;
      ctlFast <= 1'b0;
    end else begin
      if (wrLoad) loadVal <= regWrData[CNT_W-1:0];
      if (wrCtrl) begin
        ctlEn   <= regWrData[RUN_BIT];
        ctlPer  <= regWrData[PER_BIT];
        ctlFast <= regWrData[FAST_BIT];
      end
    end
  end

  always_comb begin
    strobe.doLoad = wrCtrl && newRun && !ctlEn;
    strobe.doStep = ctlEn && tickSel && !stopNow;
    strobe.clrIrq = wrAck || stopNow;
  end
endmodule

// File: rtl/reload_timer_dp.sv
module reload_timer_dp
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             ctlPer,
  output logic [CNT_W-1:0] cntVal,
  output logic             irq
);
  logic isZero, underflow;

  assign isZero    = (cntVal == '0);
  assign underflow = strobe.doStep && isZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobe.doLoad) begin
      cntVal <= loadVal;
    end else if (strobe.doStep) begin
      if (isZero) cntVal <= ctlPer ? loadVal : '1;
      else        cntVal <= cntVal - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irq <= 1'b0;
    else if (underflow)     irq <= 1'b1;
    else if (strobe.clrIrq) irq <= 1'b0;
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        fastTick,
  input  logic        slowTick,
  output logic        irq
);
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int PAD_W  = DATA_W - CNT_W;

  tmr_strobe_t      strobe;
  logic [CNT_W-1:0] loadVal, cntVal;
  logic             ctlEn, ctlPer, ctlFast;
  logic [DATA_W-1:0] loadWord, cntWord, ctlWord;

  reload_timer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .fastTick(fastTick), .slowTick(slowTick),
    .loadVal(loadVal), .ctlEn(ctlEn), .ctlPer(ctlPer), .ctlFast(ctlFast),
    .strobe(strobe)
  );

  reload_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(loadVal),
    .ctlPer(ctlPer), .cntVal(cntVal), .irq(irq)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign loadWord = {{PAD_W{1'b0}}, loadVal};
      assign cntWord  = {{PAD_W{1'b0}}, cntVal};
    end else begin : g_full
      assign loadWord = loadVal;
      assign cntWord  = cntVal;
    end
  endgenerate

  always_comb begin
    ctlWord           = '0;
    ctlWord[RUN_BIT]  = ctlEn;
    ctlWord[PER_BIT]  = ctlPer;
    ctlWord[FAST_BIT] = ctlFast;
  end

  always_comb begin
    case (regAddr[3:2])
      WIDX_LOAD:  regRdData = loadWord;
      WIDX_VALUE: regRdData = cntWord;
      WIDX_CTRL:  regRdData = ctlWord;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       regAddr,
  input logic             regWrEn,
  input logic [31:0]      regWrData,
  input logic             fastTick,
  input logic             slowTick,
  input logic             irq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] loadVal,
  input logic             ctlEn,
  input logic             ctlPer,
  input logic             ctlFast
);
  logic tick, atZero, ackWr, stopWr;
  assign tick   = ctlFast ? fastTick : slowTick;
  assign atZero = (cntVal == '0);
  assign ackWr  = regWrEn && (regAddr[3:2] == 2'd3);
  assign stopWr = regWrEn && (regAddr[3:2] == 2'd2) && !regWrData[7];

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEn && tick && !atZero && !regWrEn) |=> (cntVal == $past(cntVal) - 1'b1));

  a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlEn && !regWrEn) |=> $stable(cntVal));

  a_r6_underflow_irq: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEn && tick && atZero && !stopWr) |=> irq);

  a_r6_reload: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEn && ctlPer && tick && atZero && !regWrEn) |=> (cntVal == $past(loadVal)));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEn && !ctlPer && tick && atZero && !regWrEn) |=> (&cntVal));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && !(ctlEn && tick && atZero)) |=> !irq);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !regWrEn) |=> irq);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> !irq);
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .fastTick(fastTick), .slowTick(slowTick),
  .irq(irq), .cntVal(cntVal), .loadVal(loadVal), .ctlEn(ctlEn),
  .ctlPer(ctlPer), .ctlFast(ctlFast)
);

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        fastTick = 1'b0;
  logic        slowTick = 1'b0;
  logic [31:0] rdA, rdB;
  logic        irqA, irqB;
  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  reload_timer #(.CNT_W(32)) i_reload_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdA), .fastTick(fastTick),
    .slowTick(slowTick), .irq(irqA));

  reload_timer #(.CNT_W(16)) i_reload_timer16 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdB), .fastTick(fastTick),
    .slowTick(slowTick), .irq(irqB));

  localparam logic [3:0] A_LOAD = 4'h0, A_VAL = 4'h4, A_CTL = 4'h8, A_ACK = 4'hC;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // write with optional ticks in the same cycle
  task automatic wr(input logic [3:0] a, input logic [31:0] d,
                    input logic f = 1'b0, input logic s = 1'b0);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1; fastTick = f; slowTick = s;
    @(negedge clk);
    regWrEn = 1'b0; fastTick = 1'b0; slowTick = 1'b0;
  endtask

  task automatic pulse(input logic f, input logic s);
    @(negedge clk);
    fastTick = f; slowTick = s;
    @(negedge clk);
    fastTick = 1'b0; slowTick = 1'b0;
  endtask

  task automatic rdA_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a; #0.5;
    chk(req, rdA, exp);
  endtask

  task automatic rdB_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a; #0.5;
    chk(req, rdB, exp);
  endtask

  task automatic t_reset;
    rdA_chk("R1 load", A_LOAD, 0);
    rdA_chk("R1 value", A_VAL, 0);
    rdA_chk("R1 ctrl", A_CTL, 0);
    chk("R1 irq", {31'b0, irqA}, 0);
  endtask

  task automatic t_regs;
    wr(A_LOAD, 32'h1234_5678);
    rdA_chk("R2 load readback", A_LOAD, 32'h1234_5678);
    wr(A_VAL, 32'hFFFF_FFFF);
    rdA_chk("R2 value write ignored", A_VAL, 0);
    wr(A_CTL, 32'hFFFF_FF37);
    rdA_chk("R10 ctrl other bits", A_CTL, 0);
    wr(A_CTL, 32'h0000_0048);
    rdA_chk("R10 ctrl readback", A_CTL, 32'h48);
    rdA_chk("R5 not running", A_VAL, 0);
  endtask

  task automatic t_fast;
    wr(A_CTL, 0);
    wr(A_LOAD, 5);
    wr(A_CTL, 32'hC8, 1'b1, 1'b0);   // tick in the enabling cycle is absorbed
    rdA_chk("R3 start load", A_VAL, 5);
    repeat (3) pulse(1'b0, 1'b1);
    rdA_chk("R4 slow ignored", A_VAL, 5);
    repeat (2) pulse(1'b1, 1'b0);
    rdA_chk("R4 fast step", A_VAL, 3);
  endtask

  task automatic t_slow;
    wr(A_CTL, 0);
    wr(A_CTL, 32'hC0);
    rdA_chk("R3 reload on restart", A_VAL, 5);
    repeat (2) pulse(1'b1, 1'b0);
    rdA_chk("R4 fast ignored", A_VAL, 5);
    pulse(1'b0, 1'b1);
    rdA_chk("R4 slow step", A_VAL, 4);
  endtask

  task automatic t_hold;
    wr(A_CTL, 0, 1'b0, 1'b1);       // tick with stop write is suppressed
    rdA_chk("R9 stop suppresses tick", A_VAL, 4);
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b0);
    rdA_chk("R5 hold", A_VAL, 4);
  endtask

  task automatic t_periodic;
    wr(A_LOAD, 2);
    wr(A_CTL, 32'hC8);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    rdA_chk("R6 at zero", A_VAL, 0);
    chk("R6 no irq yet", {31'b0, irqA}, 0);
    pulse(1'b1, 1'b0);
    rdA_chk("R6 reload", A_VAL, 2);
    chk("R6 irq", {31'b0, irqA}, 1);
    pulse(1'b1, 1'b0);
    chk("R9 sticky", {31'b0, irqA}, 1);
    rdA_chk("R6 continues", A_VAL, 1);
  endtask

  task automatic t_ack;
    wr(A_ACK, 32'hDEAD_BEEF);
    chk("R8 ack clears", {31'b0, irqA}, 0);
    pulse(1'b1, 1'b0);              // 1 -> 0
    wr(A_ACK, 0, 1'b1, 1'b0);       // underflow and ack together
    chk("R8 underflow wins", {31'b0, irqA}, 1);
    rdA_chk("R8 reload", A_VAL, 2);
    wr(A_CTL, 32'h48);
    chk("R9 stop clears irq", {31'b0, irqA}, 0);
  endtask

  task automatic t_wrap;
    wr(A_LOAD, 1);
    wr(A_CTL, 32'h88);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    rdA_chk("R7 wrap", A_VAL, 32'hFFFF_FFFF);
    chk("R7 irq", {31'b0, irqA}, 1);
    pulse(1'b1, 1'b0);
    rdA_chk("R7 after wrap", A_VAL, 32'hFFFF_FFFE);
  endtask

  task automatic t_width16;
    wr(A_CTL, 0);
    wr(A_LOAD, 32'hABCD_1234);
    rdB_chk("R11 load trimmed", A_LOAD, 32'h0000_1234);
    wr(A_LOAD, 0);
    wr(A_CTL, 32'h88);
    pulse(1'b1, 1'b0);
    rdB_chk("R11 wrap 16", A_VAL, 32'h0000_FFFF);
    chk("R11 irq 16", {31'b0, irqB}, 1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1'b1;
        nChecks++; nFails++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_fast();
    t_slow();
    t_hold();
    t_periodic();
    t_ack();
    t_wrap();
    t_width16();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule